// File: doc/BRIEF.md
# Nibble-Immediate Stack Processor Core

This block is a compact processor core that executes one instruction per clock cycle from a dense instruction set. Each instruction byte carries a 6-bit opcode. The core keeps two 64-bit working registers. The accumulator `acc` is the main operand. The pointer `ptr` addresses data memory and also holds jump targets. The core also has an instruction pointer and a 16-entry hardware stack held in internal registers.

Constants are built inside the core, four bits at a time. A shift instruction and a nibble-load instruction alternate to form any value. Arithmetic and logic mostly act on the data word that `ptr` addresses. The core reads that word, combines it with `acc`, and writes it back in the same cycle.

Both memories are outside the block. The instruction port and the data read port return data combinationally from the address the core presents, and data writes take effect at the clock edge. A halt instruction stops the core so that a host can inspect memory. The core flags unassigned opcodes with a one-cycle pulse and flags stack overflow and divide-by-zero with sticky outputs.

Top module: `stk_core`

## Requirements
- R1: A synchronous active-low reset clears `acc`, `ptr`, the instruction pointer and the stack count. During reset `imem_addr` is 0, `dmem_we` is 0, and `halted`, `illegal_op`, `stk_overflow` and `div_error` are all 0.
- R2: Opcodes 0x30 to 0x3F replace bits 3:0 of `acc` with the opcode's low four bits and keep the upper bits. Opcode 0x1D shifts `acc` left by four. Opcodes 0x02 and 0x03 clear `acc`.
- R3: Data memory opcodes: 0x18 writes `acc` to data address `ptr`, and 0x19 loads `acc` from it. Register opcodes: 0x17 exchanges `acc` and `ptr`, 0x1E sets `ptr` to the parameter BASE_ADDR (default 0x80), and 0x0F adds `acc` into `ptr`. `dmem_addr` is the low AW bits of `ptr`.
- R4: Opcode 0x1C multiplies `acc` by 8. Opcode 0x0E replaces `acc` with its two's complement, and 0x04 with its bitwise inverse. Opcode 0x10 sets `acc` to 1 if `acc` ≤ `ptr` as an unsigned compare, and to 0 otherwise.
- R5: Read-modify-write opcodes write `mem[ptr] op acc` back to `mem[ptr]` in one cycle. The opcodes are 0x0D add, 0x0C multiply (low 64 bits kept), 0x0B unsigned divide, 0x09 shift left, 0x08 logical shift right, 0x07 AND, 0x06 OR and 0x05 XOR. The shift amount is `acc[5:0]` only.
- R6: A divide (0x0B) with `acc` = 0 leaves the memory word unchanged and sets `div_error`, which stays set until reset.
- R7: Opcode 0x1B pushes `acc` and opcode 0x1A pops the top of the stack into `acc`, last in first out. A pop from an empty stack loads 0 and leaves the stack count unchanged.
- R8: The stack holds 16 entries. A push while full is dropped, leaves the stored entries intact, and sets `stk_overflow`, which stays set until reset.
- R9: Opcode 0x12 jumps to `ptr`. Opcode 0x13 jumps to `ptr` when `acc` is 0 and otherwise goes to the next byte. Opcode 0x11 pushes the address of the next byte and jumps to `ptr`. A return sequence of pop, exchange and jump resumes after the call.
- R10: Opcode 0x1F sets `halted`. From then until reset, `imem_addr` holds the address of the halt byte and no data write occurs.
- R11: Unassigned opcodes (0x0A, 0x14 to 0x16, 0x20 to 0x2F) change no state. In the cycle after each one, `illegal_op` is high for one cycle. Opcodes 0x00 and 0x01 do nothing.
- R12: Every non-control instruction takes one cycle and advances `imem_addr` by one. For example, a halt placed after five no-ops raises `halted` at the sixth clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | IA_W (16) | Instruction fetch address (instruction pointer) |
| imem_data | input | 6 | Opcode bits of the instruction byte at `imem_addr` |
| dmem_addr | output | AW (16) | Data word address, low bits of `ptr` |
| dmem_rdata | input | W (64) | Data word at `dmem_addr`, combinational |
| dmem_wdata | output | W (64) | Data word to write |
| dmem_we | output | 1 | Write strobe, taken at the clock edge |
| halted | output | 1 | Core stopped by a halt opcode |
| illegal_op | output | 1 | One-cycle pulse after an unassigned opcode |
| stk_overflow | output | 1 | Sticky: a push was dropped because the stack was full |
| div_error | output | 1 | Sticky: a memory divide by zero was suppressed |

## Verification
The registers `acc` and `ptr` and the stack are not visible at the ports. A corrupted `acc` therefore shows up only at the next store, read-modify-write or conditional jump. A corrupted stack count shows up only at the next pop. So every test program ends by storing the value under test and then halting, and the bench compares the data memory image afterwards.

A wrong instruction pointer or a wrong jump decision is visible on `imem_addr` in the very next cycle. A missing halt shows up within a few cycles, because the fetch address keeps moving.

// File: rtl/stk_core_pkg.sv
// Package stk_core_pkg
// Purpose: opcode encodings shared by the core and its read-modify-write unit.
// Assumes: opcodes are six bits wide; 0x30..0x3F form the nibble-load group.
package stk_core_pkg;

    typedef enum logic [5:0] {
        OP_NOP   = 6'h00,
        OP_NOPR  = 6'h01,
        OP_CLR   = 6'h02,
        OP_CLRR  = 6'h03,
        OP_INV   = 6'h04,
        OP_MXOR  = 6'h05,
        OP_MOR   = 6'h06,
        OP_MAND  = 6'h07,
        OP_MSHR  = 6'h08,
        OP_MSHL  = 6'h09,
        OP_MDIV  = 6'h0B,
        OP_MMUL  = 6'h0C,
        OP_MADD  = 6'h0D,
        OP_NEG   = 6'h0E,
        OP_PADD  = 6'h0F,
        OP_LEQ   = 6'h10,
        OP_CALL  = 6'h11,
        OP_JMP   = 6'h12,
        OP_JZ    = 6'h13,
        OP_XCHG  = 6'h17,
        OP_ST    = 6'h18,
        OP_LD    = 6'h19,
        OP_POP   = 6'h1A,
        OP_PUSH  = 6'h1B,
        OP_X8    = 6'h1C,
        OP_NIBSH = 6'h1D,
        OP_BASE  = 6'h1E,
        OP_HALT  = 6'h1F
    } op_e;

endpackage

// File: rtl/stk_lifo.sv
// Module stk_lifo
// Purpose: register-based last-in-first-out store with an occupancy count.
// Assumes: push and pop are never requested in the same cycle (they come
// from one decoded opcode); DEPTH >= 2. A push while full and a pop while
// empty leave the count unchanged; an empty pop presents zero on dout.
module stk_lifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [CW-1:0] cnt;
    logic [IW-1:0] top_idx;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = IW'(cnt - 1'b1);
    assign dout    = empty ? '0 : slots[top_idx];

    // Occupancy count: up on an accepted push, down on an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Entry storage: write the slot just above the current top.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            slots[cnt[IW-1:0]] <= din;
        end
    end

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(cnt));

    a_r7_empty_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (cnt == '0));

endmodule

// File: rtl/stk_rmw_alu.sv
// Module stk_rmw_alu
// Purpose: combinational read-modify-write datapath for the memory word at PTR.
// Assumes: mem_word is the current word at PTR and operand is the accumulator.
// wr_ok marks a read-modify-write opcode whose result must be written back.
// A divide by zero drops the write and raises div_zero.
module stk_rmw_alu
    import stk_core_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [5:0]   opc,
    input  logic [W-1:0] mem_word,
    input  logic [W-1:0] operand,
    output logic [W-1:0] result,
    output logic         wr_ok,
    output logic         div_zero
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] shamt;
    assign shamt = operand[SW-1:0];

    // Select the memory operation and decide whether it writes back.
    always_comb begin
        result   = mem_word;
        wr_ok    = 1'b1;
        div_zero = 1'b0;
        case (opc)
            OP_MADD: result = mem_word + operand;
            OP_MMUL: result = mem_word * operand;
            OP_MSHL: result = mem_word << shamt;
            OP_MSHR: result = mem_word >> shamt;
            OP_MAND: result = mem_word & operand;
            OP_MOR:  result = mem_word | operand;
            OP_MXOR: result = mem_word ^ operand;
            OP_MDIV: begin
                if (operand == '0) begin
                    div_zero = 1'b1;
                    wr_ok    = 1'b0;
                end else begin
                    result = mem_word / operand;
                end
            end
            default: wr_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/stk_core.sv
// Module stk_core
// Purpose: single-cycle accumulator/pointer processor with a hardware stack.
// Each cycle it decodes the opcode at imem_addr, updates ACC, PTR and the
// instruction pointer, and performs at most one data-memory access at PTR.
// Assumes: both memory read ports are combinational and data writes land at
// the clock edge. W >= IA_W and W >= AW. Reset is synchronous, active low.
module stk_core
    import stk_core_pkg::*;
#(
    parameter int           W         = 64,
    parameter int           IA_W      = 16,
    parameter int           AW        = 16,
    parameter int           DEPTH     = 16,
    parameter logic [W-1:0] BASE_ADDR = 'h80
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [IA_W-1:0] imem_addr,
    input  logic [5:0]      imem_data,
    output logic [AW-1:0]   dmem_addr,
    input  logic [W-1:0]    dmem_rdata,
    output logic [W-1:0]    dmem_wdata,
    output logic            dmem_we,
    output logic            halted,
    output logic            illegal_op,
    output logic            stk_overflow,
    output logic            div_error
);
    logic [W-1:0]    acc_q, acc_d, ptr_q, ptr_d;
    logic [IA_W-1:0] ip_q, ip_d, ip_inc;
    logic            halt_q, ill_q, ovf_q, dz_q;
    logic            run, do_push, do_pop, do_store, bad_op, stop;
    logic [W-1:0]    push_word, stk_top, alu_res;
    logic            stk_full, stk_empty, alu_wr, alu_dz;
    logic [5:0]      opc;

    assign opc    = imem_data;
    assign run    = rst_n && !halt_q;
    assign ip_inc = ip_q + 1'b1;

    // Decode the current opcode into next-state values and side requests.
    always_comb begin
        acc_d     = acc_q;
        ptr_d     = ptr_q;
        ip_d      = ip_inc;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        do_store  = 1'b0;
        bad_op    = 1'b0;
        stop      = 1'b0;
        push_word = acc_q;
        if (opc[5:4] == 2'b11) begin
            acc_d = {acc_q[W-1:4], opc[3:0]};
        end else begin
            case (opc)
                OP_NOP, OP_NOPR: ;
                OP_CLR, OP_CLRR: acc_d = '0;
                OP_INV:   acc_d = ~acc_q;
                OP_NEG:   acc_d = '0 - acc_q;
                OP_PADD:  ptr_d = ptr_q + acc_q;
                OP_LEQ:   acc_d = (acc_q <= ptr_q) ? {{(W-1){1'b0}}, 1'b1} : '0;
                OP_CALL: begin
                    do_push   = 1'b1;
                    push_word = W'(ip_inc);
                    ip_d      = ptr_q[IA_W-1:0];
                end
                OP_JMP:   ip_d = ptr_q[IA_W-1:0];
                OP_JZ:    if (acc_q == '0) ip_d = ptr_q[IA_W-1:0];
                OP_XCHG: begin
                    acc_d = ptr_q;
                    ptr_d = acc_q;
                end
                OP_ST:    do_store = 1'b1;
                OP_LD:    acc_d = dmem_rdata;
                OP_POP: begin
                    do_pop = 1'b1;
                    acc_d  = stk_top;
                end
                OP_PUSH:  do_push = 1'b1;
                OP_X8:    acc_d = {acc_q[W-4:0], 3'b000};
                OP_NIBSH: acc_d = {acc_q[W-5:0], 4'h0};
                OP_BASE:  ptr_d = BASE_ADDR;
                OP_HALT: begin
                    stop = 1'b1;
                    ip_d = ip_q;
                end
                OP_MADD, OP_MMUL, OP_MDIV, OP_MSHL,
                OP_MSHR, OP_MAND, OP_MOR, OP_MXOR: ;
                default:  bad_op = 1'b1;
            endcase
        end
    end

    stk_lifo #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (run && do_push),
        .pop   (run && do_pop),
        .din   (push_word),
        .dout  (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    stk_rmw_alu #(.W(W)) u_rmw (
        .opc      (opc),
        .mem_word (dmem_rdata),
        .operand  (acc_q),
        .result   (alu_res),
        .wr_ok    (alu_wr),
        .div_zero (alu_dz)
    );

    // Architectural state and status flags; all frozen once halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            ptr_q  <= '0;
            ip_q   <= '0;
            halt_q <= 1'b0;
            ill_q  <= 1'b0;
            ovf_q  <= 1'b0;
            dz_q   <= 1'b0;
        end else begin
            ill_q <= 1'b0;
            if (!halt_q) begin
                acc_q  <= acc_d;
                ptr_q  <= ptr_d;
                ip_q   <= ip_d;
                halt_q <= stop;
                ill_q  <= bad_op;
                if (do_push && stk_full) ovf_q <= 1'b1;
                if (alu_dz) dz_q <= 1'b1;
            end
        end
    end

    assign imem_addr    = ip_q;
    assign dmem_addr    = ptr_q[AW-1:0];
    assign dmem_we      = run && (do_store || alu_wr);
    assign dmem_wdata   = do_store ? acc_q : alu_res;
    assign halted       = halt_q;
    assign illegal_op   = ill_q;
    assign stk_overflow = ovf_q;
    assign div_error    = dz_q;

    a_r10_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));

    a_r6_div_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (run && opc == OP_MDIV && acc_q == '0) |-> !dmem_we);

    a_r6_div_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        div_error |=> div_error);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_overflow |=> stk_overflow);

    a_r9_jz_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (run && opc == OP_JZ && acc_q != '0) |=>
            (imem_addr == $past(imem_addr) + 1'b1));

    a_r11_no_store_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bad_op) |-> !dmem_we);

endmodule

// File: tb/tb_stk_core.sv
`timescale 1ns/1ps
module tb_stk_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr;
    logic [5:0]  imem_data;
    logic [15:0] dmem_addr;
    logic [63:0] dmem_rdata, dmem_wdata;
    logic        dmem_we, halted, illegal_op, stk_overflow, div_error;

    logic [7:0]  imem [256];
    logic [63:0] dmem [256];
    int          pg;
    int          checks = 0;
    int          errors = 0;
    int          ill_cnt = 0;

    always #4 clk = ~clk;

    stk_core dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .halted(halted), .illegal_op(illegal_op),
        .stk_overflow(stk_overflow), .div_error(div_error)
    );

    assign imem_data  = imem[imem_addr[7:0]][5:0];
    assign dmem_rdata = dmem[dmem_addr[7:0]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    always @(negedge clk) if (rst_n && illegal_op) ill_cnt++;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act,
                          input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic fresh();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 8'h1F;
            dmem[i] = 64'h0;
        end
        pg = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        imem[pg] = b;
        pg++;
    endtask

    task automatic ldv(input logic [15:0] c);
        emit(8'h02);
        for (int i = 3; i >= 0; i--) begin
            emit(8'h1D);
            emit(8'h30 | {4'h0, c[i*4 +: 4]});
        end
    endtask

    task automatic ldv64(input logic [63:0] c);
        emit(8'h02);
        for (int i = 15; i >= 0; i--) begin
            emit(8'h1D);
            emit(8'h30 | {4'h0, c[i*4 +: 4]});
        end
    endtask

    task automatic setp(input logic [15:0] c);
        ldv(c);
        emit(8'h17);
    endtask

    task automatic run_prog();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ill_cnt = 0;
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        chk_eq("R10 program reached halt", {63'h0, halted}, 64'h1);
    endtask

    task automatic t_timing();
        fresh();
        for (int i = 0; i < 5; i++) emit(8'h00);
        emit(8'h1F);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        chk_eq("R12 not halted after five edges", {63'h0, halted}, 64'h0);
        chk_eq("R12 fetch address after five edges", {48'h0, imem_addr}, 64'd5);
        @(posedge clk);
        #1;
        chk_eq("R12 halted at sixth edge", {63'h0, halted}, 64'h1);
        repeat (4) @(posedge clk);
        #1;
        chk_eq("R10 fetch address held", {48'h0, imem_addr}, 64'd5);
        chk_eq("R10 halted held", {63'h0, halted}, 64'h1);
    endtask

    task automatic t_constants();
        fresh();
        setp(16'h00B0);
        emit(8'h02); emit(8'h3F); emit(8'h33); emit(8'h1D); emit(8'h3A);
        emit(8'h18);
        setp(16'h00B1);
        ldv64(64'h0123_4567_89AB_CDEF);
        emit(8'h18);
        setp(16'h00B2);
        ldv(16'h1234); emit(8'h03); emit(8'h18);
        setp(16'h00B3);
        ldv(16'h00F0); emit(8'h35); emit(8'h18);
        emit(8'h1F);
        run_prog();
        chk_eq("R2 nibble replace then shift", dmem[8'hB0], 64'h3A);
        chk_eq("R2 64-bit constant", dmem[8'hB1], 64'h0123_4567_89AB_CDEF);
        chk_eq("R2 clear opcode 0x03", dmem[8'hB2], 64'h0);
        chk_eq("R2 nibble keeps upper bits", dmem[8'hB3], 64'hF5);
    endtask

    task automatic t_regs();
        fresh();
        dmem[8'h40] = 64'hDEAD_BEEF_0055_AA11;
        setp(16'h0040); emit(8'h19); emit(8'h1B);
        setp(16'h0041); emit(8'h1A); emit(8'h18);
        setp(16'h0090); ldv(16'h00A1); emit(8'h17); emit(8'h18);
        emit(8'h1E); ldv(16'h0009); emit(8'h18);
        setp(16'h0060); ldv(16'h0002); emit(8'h0F); ldv(16'h0007); emit(8'h18);
        emit(8'h1F);
        run_prog();
        chk_eq("R3 load then store", dmem[8'h41], 64'hDEAD_BEEF_0055_AA11);
        chk_eq("R3 exchange", dmem[8'hA1], 64'h90);
        chk_eq("R3 base address", dmem[8'h80], 64'h9);
        chk_eq("R3 pointer add", dmem[8'h62], 64'h7);
        chk_eq("R3 pointer add leaves old word", dmem[8'h60], 64'h0);
    endtask

    task automatic t_acc_ops();
        fresh();
        setp(16'h0010); ldv(16'h0003); emit(8'h1C); emit(8'h18);
        setp(16'h0011); ldv(16'h0005); emit(8'h0E); emit(8'h18);
        setp(16'h0012); ldv(16'h0005); emit(8'h04); emit(8'h18);
        setp(16'h0050); ldv(16'h0050); emit(8'h10); emit(8'h18);
        setp(16'h0051); ldv(16'h0052); emit(8'h10); emit(8'h18);
        setp(16'h0052); ldv(16'h0003); emit(8'h10); emit(8'h18);
        emit(8'h1F);
        run_prog();
        chk_eq("R4 times eight", dmem[8'h10], 64'd24);
        chk_eq("R4 two's complement", dmem[8'h11], 64'hFFFF_FFFF_FFFF_FFFB);
        chk_eq("R4 bitwise inverse", dmem[8'h12], 64'hFFFF_FFFF_FFFF_FFFA);
        chk_eq("R4 compare equal", dmem[8'h50], 64'd1);
        chk_eq("R4 compare greater", dmem[8'h51], 64'd0);
        chk_eq("R4 compare less", dmem[8'h52], 64'd1);
    endtask

    task automatic rmw_case(input logic [7:0] op, input logic [63:0] a,
                            input logic [15:0] b, input logic [63:0] exp,
                            input string tag);
        fresh();
        dmem[8'h20] = a;
        setp(16'h0020); ldv(b); emit(op); emit(8'h1F);
        run_prog();
        chk_eq(tag, dmem[8'h20], exp);
    endtask

    task automatic t_rmw();
        logic [63:0] a;
        a = 64'h1234_5678_9ABC_DEF0;
        rmw_case(8'h0D, a, 16'h1111, a + 64'h1111, "R5 add");
        rmw_case(8'h0C, a, 16'h0123, a * 64'h0123, "R5 multiply");
        rmw_case(8'h0B, a, 16'h0007, a / 64'h7, "R5 divide");
        chk_eq("R6 no error on nonzero divide", {63'h0, div_error}, 64'h0);
        rmw_case(8'h09, a, 16'h0044, a << 4, "R5 shift left low six bits");
        rmw_case(8'h08, a, 16'h00C8, a >> 8, "R5 shift right low six bits");
        rmw_case(8'h07, a, 16'hF0F0, a & 64'hF0F0, "R5 and");
        rmw_case(8'h06, a, 16'h000F, a | 64'h000F, "R5 or");
        rmw_case(8'h05, a, 16'hFFFF, a ^ 64'hFFFF, "R5 xor");
        rmw_case(8'h0B, a, 16'h0000, a, "R6 divide by zero keeps word");
        chk_eq("R6 divide error set", {63'h0, div_error}, 64'h1);
    endtask

    task automatic t_stack();
        fresh();
        dmem[8'hD3] = 64'hFFFF;
        ldv(16'h0001); emit(8'h1B);
        ldv(16'h0002); emit(8'h1B);
        ldv(16'h0003); emit(8'h1B);
        setp(16'h00D0); emit(8'h1A); emit(8'h18);
        setp(16'h00D1); emit(8'h1A); emit(8'h18);
        setp(16'h00D2); emit(8'h1A); emit(8'h18);
        setp(16'h00D3); emit(8'h1A); emit(8'h18);
        setp(16'h00D4); ldv(16'h0009); emit(8'h1B); emit(8'h1A); emit(8'h18);
        emit(8'h1F);
        run_prog();
        chk_eq("R7 pop order first", dmem[8'hD0], 64'd3);
        chk_eq("R7 pop order second", dmem[8'hD1], 64'd2);
        chk_eq("R7 pop order third", dmem[8'hD2], 64'd1);
        chk_eq("R7 empty pop gives zero", dmem[8'hD3], 64'd0);
        chk_eq("R7 count unchanged by empty pop", dmem[8'hD4], 64'd9);
        chk_eq("R8 no overflow under depth", {63'h0, stk_overflow}, 64'h0);
    endtask

    task automatic t_overflow();
        fresh();
        for (int i = 1; i <= 17; i++) begin
            ldv(16'(i));
            emit(8'h1B);
        end
        setp(16'h00D5); emit(8'h1A); emit(8'h18);
        emit(8'h1F);
        run_prog();
        chk_eq("R8 top after dropped push", dmem[8'hD5], 64'd16);
        chk_eq("R8 overflow flag", {63'h0, stk_overflow}, 64'h1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk_eq("R1 fetch address", {48'h0, imem_addr}, 64'h0);
        chk_eq("R1 flags clear",
               {60'h0, halted, illegal_op, stk_overflow, div_error}, 64'h0);
        chk_eq("R1 no write in reset", {63'h0, dmem_we}, 64'h0);
    endtask

    task automatic t_control();
        int ret;
        fresh();
        setp(16'h0040);
        ret = pg + 1;
        emit(8'h11);
        setp(16'h00C1); ldv(16'h0077); emit(8'h18); emit(8'h1F);
        pg = 8'h40;
        setp(16'h00C0); emit(8'h1A); emit(8'h18); emit(8'h17); emit(8'h12);
        run_prog();
        chk_eq("R9 call pushes return address", dmem[8'hC0], 64'(ret));
        chk_eq("R9 return resumes after call", dmem[8'hC1], 64'h77);

        fresh();
        setp(16'h0050); emit(8'h12);
        pg = 8'h50;
        setp(16'h00C2); ldv(16'h0011); emit(8'h18); emit(8'h1F);
        run_prog();
        chk_eq("R9 unconditional jump", dmem[8'hC2], 64'h11);

        fresh();
        setp(16'h0060); emit(8'h02); emit(8'h13);
        pg = 8'h60;
        setp(16'h00C3); ldv(16'h0022); emit(8'h18); emit(8'h1F);
        run_prog();
        chk_eq("R9 jump on zero taken", dmem[8'hC3], 64'h22);

        fresh();
        setp(16'h0060); ldv(16'h0001); emit(8'h13);
        setp(16'h00C4); ldv(16'h0033); emit(8'h18); emit(8'h1F);
        pg = 8'h60;
        setp(16'h00C4); ldv(16'h0099); emit(8'h18); emit(8'h1F);
        run_prog();
        chk_eq("R9 jump on zero not taken", dmem[8'hC4], 64'h33);
    endtask

    task automatic t_illegal();
        fresh();
        setp(16'h00E0); ldv(16'h0005);
        emit(8'h2A); emit(8'h00); emit(8'h01); emit(8'h14); emit(8'h0A);
        emit(8'h18); emit(8'h1F);
        run_prog();
        chk_eq("R11 unassigned opcodes leave state", dmem[8'hE0], 64'h5);
        chk_eq("R11 illegal pulse cycles", 64'(ill_cnt), 64'd3);
        chk_eq("R11 pulse gone at halt", {63'h0, illegal_op}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fresh();
        t_timing();
        t_constants();
        t_regs();
        t_acc_ops();
        t_rmw();
        t_stack();
        t_overflow();
        t_reset();
        t_control();
        t_illegal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule